// File: doc/BRIEF.md
# Key-Locked Core Control Register Bank

This block is a small memory-mapped register bank sitting on a simple 32-bit read/write bus inside a 4 KB address window. It holds the reset and clock-stop controls for two processor cores and drives a halt line and a reset line for each core from them. A few fixed read-only registers report constant clock-generator settings and a constant PLL status word.

The core controls are guarded by a write-protection latch that is set out of reset. Software opens the bank by writing a 16-bit magic key to the unlock register. It closes the bank again by writing a different key to the lock register, and it can read the latch state from a status register. Wrong keys leave the latch alone and raise a one-cycle pulse. A write to the core control register that is blocked by the latch, and that would have changed it, raises a separate one-cycle pulse.

Reads take one cycle: the address is sampled on the clock edge where `bus_rd` is high, and the data appears on `bus_rdata` after that edge. Key writes change the latch on the edge that accepts them.

Top module: `keylock_sysctl`

## Requirements
- R1: After reset, protection is on, every core control bit is 0, `core_halt` and `core_rst` are all 0, and both pulse outputs are 0.
- R2: A write whose bits [15:0] equal 0xDF0D to byte offset 0x008 clears protection on that edge. Bits [31:16] of the write do not matter.
- R3: A write whose bits [15:0] equal 0x767B to byte offset 0x004 sets protection on that edge. Any other key value on either key register leaves protection unchanged.
- R4: Offset 0x00C reads 1 in bit 0 while protection is on and 0 when it is off. All its other bits read 0.
- R5: The core control register at offset 0x244 holds core 0 reset in bit 0, core 1 reset in bit 1, core 0 clock stop in bit 4, core 1 clock stop in bit 5 and an inert soft-reset flag in bit 8. While unlocked, a write stores these five bits, and a read returns them with every other bit 0.
- R6: While protection is on, writes to offset 0x244 are discarded and all five stored bits keep their values.
- R7: `core_halt[i]` is high when core i's reset bit or clock-stop bit is set. `core_rst[i]` equals core i's reset bit. The soft-reset flag drives neither output.
- R8: Offsets 0x100, 0x104 and 0x108 each read 0x0001A008, and offset 0x10C reads 0x0000003F. Writes to them do not change these values.
- R9: `bad_key_pulse` is high for exactly the cycle after a write to a key register whose bits [15:0] are not that register's key.
- R10: `blocked_wr_pulse` is high for exactly the cycle after a write to 0x244 that protection blocked and whose five live bits differ from the stored ones. A blocked write of identical values gives no pulse.
- R11: Unmapped offsets, misaligned addresses and both key registers read 0. Writes to unmapped offsets change no state and raise no pulse.
- R12: Read data appears on `bus_rdata` one clock after the edge that samples `bus_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_halt | output | NUM_CORES | Per-core halt request |
| core_rst | output | NUM_CORES | Per-core reset request |
| bad_key_pulse | output | 1 | One-cycle flag for a wrong key |
| blocked_wr_pulse | output | 1 | One-cycle flag for a blocked value-changing write |

## Verification
The bench sweeps all 32 combinations of the five live control bits, once while locked and once while unlocked. Reserved bits are set in every write. This catches a design that lets a locked write through, that mixes up the reset and stop bit positions, that stores reserved bits, or that lets the soft-reset flag drive a halt. The key registers are hit with near-miss keys and with the other register's key, and the matching key is sent with junk in the upper half. A design that compares 32 bits, checks only part of the key, or toggles instead of setting would either fail to change the latch or raise the wrong pulse. A full read sweep of the window, plus writes to holes and to constant registers, exposes aliasing from partial address decode.

// File: rtl/keylock_pkg.sv
// Package: shared constants for the key-locked control register bank.
// Assumes a 4 KB window with 32-bit data; offsets are full byte addresses.
package keylock_pkg;
    localparam int unsigned WIN_BYTES = 4096;
    localparam int unsigned ADDR_W    = $clog2(WIN_BYTES);
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned KEY_W     = 16;

    localparam logic [ADDR_W-1:0] OFF_LOCK     = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_UNLOCK   = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_PLL_A    = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_PLL_B    = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_PLL_C    = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_PLL_STAT = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_CORE     = 12'h244;

    localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;
    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;

    localparam logic [DATA_W-1:0] PLL_CTRL_WORD = 32'h0001_A008;
    localparam logic [DATA_W-1:0] PLL_STAT_WORD = 32'h0000_003F;

    // Bit positions inside the core control word (decoded by software).
    localparam int unsigned RST_BASE  = 0;
    localparam int unsigned STOP_BASE = 4;
    localparam int unsigned SOFT_BIT  = 8;
    localparam int unsigned MAX_CORES = STOP_BASE - RST_BASE;
endpackage

// File: rtl/keylock_guard.sv
// Module: write-protection latch with key compare.
// Sets on the closing key, clears on the opening key, and flags any wrong
// key with a registered one-cycle pulse. Assumes at most one of the two
// key strobes is high in a cycle (they decode distinct addresses).
module keylock_guard
    import keylock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             close_wr,
    input  logic             open_wr,
    input  logic [KEY_W-1:0] key_in,
    output logic             prot_on,
    output logic             bad_key
);
    logic close_ok;
    logic open_ok;

    // Compare the key field against each register's own key.
    always_comb begin
        close_ok = close_wr && (key_in == KEY_CLOSE);
        open_ok  = open_wr  && (key_in == KEY_OPEN);
    end

    // Update the latch on the accepting edge; register the wrong-key flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on <= 1'b1;
            bad_key <= 1'b0;
        end else begin
            if (close_ok) begin
                prot_on <= 1'b1;
            end else if (open_ok) begin
                prot_on <= 1'b0;
            end
            bad_key <= (close_wr && !close_ok) || (open_wr && !open_ok);
        end
    end
endmodule

// File: rtl/keylock_core_ctrl.sv
// Module: per-core reset and clock-stop storage plus the inert soft flag.
// Stores only when unlocked, drives halt and reset per core, and pulses
// when a locked write would have changed the stored bits.
// Assumes NUM_CORES <= MAX_CORES so reset and stop fields do not overlap.
module keylock_core_ctrl
    import keylock_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 prot_on,
    output logic [DATA_W-1:0]    ctrl_word,
    output logic [NUM_CORES-1:0] core_halt,
    output logic [NUM_CORES-1:0] core_rst,
    output logic                 blocked
);
    // Mask of the bits that hold state in the control word.
    function automatic logic [DATA_W-1:0] live_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(NUM_CORES); i++) begin
            m[RST_BASE + i]  = 1'b1;
            m[STOP_BASE + i] = 1'b1;
        end
        m[SOFT_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LIVE = live_mask();

    logic [NUM_CORES-1:0] rst_q;
    logic [NUM_CORES-1:0] stop_q;
    logic                 soft_q;
    logic                 take;

    assign take = wr_en && !prot_on;

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        // Hold this core's reset and stop requests.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rst_q[g]  <= 1'b0;
                stop_q[g] <= 1'b0;
            end else if (take) begin
                rst_q[g]  <= wdata[RST_BASE + g];
                stop_q[g] <= wdata[STOP_BASE + g];
            end
        end
        // Halt covers both a stop request and a held reset.
        assign core_halt[g] = rst_q[g] | stop_q[g];
        assign core_rst[g]  = rst_q[g];
    end

    // Hold the soft-reset flag, which drives nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_q <= 1'b0;
        end else if (take) begin
            soft_q <= wdata[SOFT_BIT];
        end
    end

    // Assemble the readable view of the stored bits.
    always_comb begin
        ctrl_word = '0;
        for (int i = 0; i < int'(NUM_CORES); i++) begin
            ctrl_word[RST_BASE + i]  = rst_q[i];
            ctrl_word[STOP_BASE + i] = stop_q[i];
        end
        ctrl_word[SOFT_BIT] = soft_q;
    end

    // Flag a locked write that would have changed stored bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else begin
            blocked <= wr_en && prot_on && ((wdata & LIVE) != ctrl_word);
        end
    end
endmodule

// File: rtl/keylock_read_path.sv
// Module: address decode for reads and the registered read-data port.
// Full-address compare, so misaligned and unmapped reads return zero.
// Data is captured on the edge that samples the read strobe and then held.
module keylock_read_path
    import keylock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prot_on,
    input  logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    // Pick the word for the sampled address.
    always_comb begin
        case (addr)
            OFF_STATUS:                       sel = {{(DATA_W-1){1'b0}}, prot_on};
            OFF_PLL_A, OFF_PLL_B, OFF_PLL_C:  sel = PLL_CTRL_WORD;
            OFF_PLL_STAT:                     sel = PLL_STAT_WORD;
            OFF_CORE:                         sel = ctrl_word;
            default:                          sel = '0;
        endcase
    end

    // Register read data one cycle after the strobe and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= sel;
        end
    end
endmodule

// File: rtl/keylock_sysctl.sv
// Module: top of the key-locked control register bank.
// Decodes bus writes to the two key registers and the core control
// register, and wires the guard, core storage and read path together.
// Assumes the bus issues at most one access per cycle.
module keylock_sysctl
    import keylock_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] core_halt,
    output logic [NUM_CORES-1:0] core_rst,
    output logic                 bad_key_pulse,
    output logic                 blocked_wr_pulse
);
    logic              wr_close;
    logic              wr_open;
    logic              wr_core;
    logic              prot_on;
    logic [DATA_W-1:0] ctrl_word;

    // Decode write strobes on the full byte address.
    always_comb begin
        wr_close = bus_wr && (bus_addr == OFF_LOCK);
        wr_open  = bus_wr && (bus_addr == OFF_UNLOCK);
        wr_core  = bus_wr && (bus_addr == OFF_CORE);
    end

    keylock_guard u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .close_wr (wr_close),
        .open_wr  (wr_open),
        .key_in   (bus_wdata[KEY_W-1:0]),
        .prot_on  (prot_on),
        .bad_key  (bad_key_pulse)
    );

    keylock_core_ctrl #(.NUM_CORES(NUM_CORES)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_core),
        .wdata     (bus_wdata),
        .prot_on   (prot_on),
        .ctrl_word (ctrl_word),
        .core_halt (core_halt),
        .core_rst  (core_rst),
        .blocked   (blocked_wr_pulse)
    );

    keylock_read_path u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .prot_on   (prot_on),
        .ctrl_word (ctrl_word),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/keylock_sysctl_chk.sv
// Module: property checker bound to the register bank top.
// Watches the bus, the protection latch and the core outputs.
module keylock_sysctl_chk
    import keylock_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [KEY_W-1:0]     key_field,
    input logic                 prot_on,
    input logic [NUM_CORES-1:0] core_halt,
    input logic [NUM_CORES-1:0] core_rst,
    input logic                 bad_key_pulse,
    input logic                 blocked_wr_pulse
);
    AST_OPEN_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_UNLOCK && key_field == KEY_OPEN) |=> !prot_on); // R2

    AST_CLOSE_KEY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_LOCK && key_field == KEY_CLOSE) |=> prot_on); // R3

    AST_LOCKED_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        prot_on |=> ($stable(core_halt) && $stable(core_rst))); // R6

    AST_RESET_IMPLIES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst & ~core_halt) == '0); // R7

    AST_BAD_KEY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_key_pulse |-> $past(bus_wr)); // R9

    AST_BLOCK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_wr_pulse |-> ($past(prot_on) && $past(bus_wr) && $past(bus_addr) == OFF_CORE)); // R10
endmodule

bind keylock_sysctl keylock_sysctl_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_wr           (bus_wr),
    .bus_addr         (bus_addr),
    .key_field        (bus_wdata[KEY_W-1:0]),
    .prot_on          (prot_on),
    .core_halt        (core_halt),
    .core_rst         (core_rst),
    .bad_key_pulse    (bad_key_pulse),
    .blocked_wr_pulse (blocked_wr_pulse)
);

// File: tb/keylock_sysctl_test.sv
// Bench: sweeps the control bits locked and unlocked, probes keys and the
// whole address window, and compares against values derived from the
// requirements.
module keylock_sysctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  core_halt;
    logic [1:0]  core_rst;
    logic        bad_key_pulse;
    logic        blocked_wr_pulse;

    int checks = 0;
    int fails  = 0;

    keylock_sysctl #(.NUM_CORES(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_halt(core_halt), .core_rst(core_rst),
        .bad_key_pulse(bad_key_pulse), .blocked_wr_pulse(blocked_wr_pulse)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Five live bits v[4:0] placed at their register positions (R5).
    function automatic logic [31:0] place(input int v);
        return {23'd0, v[4], 2'b00, v[3], v[2], 2'b00, v[1], v[0]};
    endfunction

    // Expected read value of an address given the core word and lock state.
    function automatic logic [31:0] expect_rd(input logic [11:0] a, input logic [31:0] core, input logic lk);
        if (a == 12'h00C) return {31'd0, lk};
        if (a == 12'h100 || a == 12'h104 || a == 12'h108) return 32'h0001_A008;
        if (a == 12'h10C) return 32'h0000_003F;
        if (a == 12'h244) return core;
        return 32'h0;
    endfunction

    localparam logic [31:0] JUNK = 32'hFFFF_FECC;

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] word;

        // R1 reset state
        do_reset();
        chk("R1 halt after reset", {30'd0, core_halt}, 32'd0);
        chk("R1 rst after reset", {30'd0, core_rst}, 32'd0);
        chk("R1 pulses after reset", {30'd0, bad_key_pulse, blocked_wr_pulse}, 32'd0);
        bus_read(12'h00C, rd); chk("R1 R4 status locked", rd, 32'd1);
        bus_read(12'h244, rd); chk("R1 core word zero", rd, 32'd0);

        // R8 constants, R12 latency
        bus_read(12'h100, rd); chk("R8 pll a", rd, 32'h0001_A008);
        bus_read(12'h104, rd); chk("R8 pll b", rd, 32'h0001_A008);
        bus_read(12'h108, rd); chk("R8 pll c", rd, 32'h0001_A008);
        @(negedge clk); bus_rd = 1'b1; bus_addr = 12'h10C;
        chk("R12 rdata held before edge", bus_rdata, 32'h0001_A008);
        @(negedge clk); bus_rd = 1'b0; bus_addr = 12'h000;
        chk("R12 R8 pll status one cycle later", bus_rdata, 32'h0000_003F);
        @(negedge clk);
        chk("R12 rdata held after strobe", bus_rdata, 32'h0000_003F);

        // R6 R10 locked sweep from an all-zero word
        for (int v = 0; v < 32; v++) begin
            bus_write(12'h244, place(v) | JUNK);
            chk("R10 blocked pulse when changing", {31'd0, blocked_wr_pulse}, {31'd0, (v != 0)});
            chk("R6 halt held while locked", {30'd0, core_halt}, 32'd0);
            chk("R6 rst held while locked", {30'd0, core_rst}, 32'd0);
        end
        bus_read(12'h244, rd); chk("R6 word held while locked", rd, 32'd0);
        chk("R10 pulse is one cycle", {31'd0, blocked_wr_pulse}, 32'd0);

        // R3 R9 wrong keys on the open register keep protection
        for (int k = 0; k < 6; k++) begin
            case (k)
                0: word = 32'h0000_0000;
                1: word = 32'h0000_DF0C;
                2: word = 32'h0000_5F0D;
                3: word = 32'h0000_767B;
                4: word = 32'hFFFF_DF0F;
                default: word = 32'h0001_0000;
            endcase
            bus_write(12'h008, word);
            chk("R9 wrong open key pulse", {31'd0, bad_key_pulse}, 32'd1);
            bus_read(12'h00C, rd); chk("R3 wrong key keeps lock", rd, 32'd1);
            chk("R9 pulse is one cycle", {31'd0, bad_key_pulse}, 32'd0);
        end

        // R2 correct key with junk in the upper half
        bus_write(12'h008, 32'hA5A5_DF0D);
        chk("R2 R9 right key no pulse", {31'd0, bad_key_pulse}, 32'd0);
        bus_read(12'h00C, rd); chk("R2 R4 unlocked status", rd, 32'd0);

        // R3 wrong close keys leave it open
        bus_write(12'h004, 32'h0000_DF0D);
        chk("R9 wrong close key pulse", {31'd0, bad_key_pulse}, 32'd1);
        bus_write(12'h004, 32'h0000_767A);
        chk("R9 near close key pulse", {31'd0, bad_key_pulse}, 32'd1);
        bus_read(12'h00C, rd); chk("R3 wrong close key keeps open", rd, 32'd0);

        // R5 R7 unlocked sweep
        for (int v = 0; v < 32; v++) begin
            bus_write(12'h244, place(v) | JUNK);
            chk("R10 no pulse when unlocked", {31'd0, blocked_wr_pulse}, 32'd0);
            chk("R7 halt", {30'd0, core_halt}, {30'd0, v[1] | v[3], v[0] | v[2]});
            chk("R7 rst", {30'd0, core_rst}, {30'd0, v[1], v[0]});
            bus_read(12'h244, rd); chk("R5 readback", rd, place(v));
        end

        // R3 close, then R10 same-value and R6 changing writes
        bus_write(12'h244, place(15));
        bus_write(12'h004, 32'hFFFF_767B);
        chk("R3 right close key no pulse", {31'd0, bad_key_pulse}, 32'd0);
        bus_read(12'h00C, rd); chk("R3 R4 locked again", rd, 32'd1);
        bus_write(12'h244, place(15) | JUNK);
        chk("R10 same value no pulse", {31'd0, blocked_wr_pulse}, 32'd0);
        bus_write(12'h244, 32'd0);
        chk("R10 changing value pulse", {31'd0, blocked_wr_pulse}, 32'd1);
        chk("R6 halt kept", {30'd0, core_halt}, 32'd3);
        chk("R6 rst kept", {30'd0, core_rst}, 32'd3);
        bus_read(12'h244, rd); chk("R6 word kept", rd, place(15));

        // R11 unmapped writes while unlocked
        bus_write(12'h008, 32'h0000_DF0D);
        bus_write(12'h244, place(17));
        for (int n = 0; n < 6; n++) begin
            logic [11:0] a;
            case (n)
                0: a = 12'h000;
                1: a = 12'h240;
                2: a = 12'h246;
                3: a = 12'h248;
                4: a = 12'hFFC;
                default: a = 12'h10C;
            endcase
            bus_write(a, 32'hFFFF_FFFF);
            chk("R11 no pulse on unmapped write", {30'd0, bad_key_pulse, blocked_wr_pulse}, 32'd0);
            chk("R11 halt unchanged", {30'd0, core_halt}, 32'd1);
        end
        bus_read(12'h244, rd); chk("R11 core word unchanged", rd, place(17));
        bus_read(12'h10C, rd); chk("R8 constant survives write", rd, 32'h0000_003F);

        // R11 full window read sweep, including misaligned probes
        for (int a = 0; a < 4096; a += 4) begin
            bus_read(a[11:0], rd);
            chk("R11 R4 R8 window sweep", rd, expect_rd(a[11:0], place(17), 1'b0));
        end
        bus_read(12'h245, rd); chk("R11 misaligned reads zero", rd, 32'd0);
        bus_read(12'h00D, rd); chk("R11 misaligned status zero", rd, 32'd0);

        // R1 reset again from an unlocked, populated state
        bus_write(12'h244, place(31));
        do_reset();
        chk("R1 halt cleared by reset", {30'd0, core_halt}, 32'd0);
        bus_read(12'h00C, rd); chk("R1 lock restored", rd, 32'd1);
        bus_read(12'h244, rd); chk("R1 word cleared", rd, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule